// File: doc/BRIEF.md
# Idle-Column Rate-Compensation Elastic Buffer

This block sits on the receive side of a four-lane link, after the lanes have been deskewed. Each column it accepts is four bytes wide, one byte per lane, and each byte carries a control flag. Columns arrive on the recovered clock and leave on the local clock. The two clocks run at nominally the same rate but are not locked to each other, so the buffer keeps its fill level near half depth. It drops a complete idle column when it runs full and repeats one when it runs empty. It never adds or removes a single lane's byte, so the column structure that later stages parse is kept intact.

An idle column is one in which all four lanes hold the idle byte `8'h07` with the control flag set. On the write side, an incoming idle column is discarded when the write-side fill estimate is above the delete threshold. On the read side, when the read-side fill estimate is below the insert threshold and the column at the head is idle, that column is sent out without advancing the read pointer, which places an extra idle column directly after it. Both adjustments are allowed only while the lane-sync input is high. The write and read pointers cross between the clock domains in Gray code.

If the buffer still overruns, the incoming column is dropped and a sticky overflow flag is set. New columns are then refused until the fill falls back to half. If the buffer runs dry, idle columns are sent out and a sticky underflow flag is set. Reading stays paused until the fill climbs back to half.

Top module: `column_elastic_buf`

## Requirements
- R1: After reset the outputs present an idle column (every lane `8'h07`, every control flag 1), and both error flags are 0.
- R2: While in sync and free of errors, every column that is not idle leaves the buffer unchanged and in the order it was written, with none lost and none duplicated.
- R3: With lane sync high and a write-side fill above 10 columns, an incoming idle column is discarded. A faster write clock therefore yields fewer idle columns at the output than were written.
- R4: With lane sync high, a read-side fill below 6 and an idle column at the head, that idle column is sent out again on the next cycle. A faster read clock therefore yields more idle columns at the output than were written.
- R5: A column is idle only when all four lanes (lane i in data bits 8i+7:8i, flag in control bit i) hold `8'h07` and all four flags are 1. Columns with some idle lanes or some flags cleared pass through as data.
- R6: With lane sync low, no column is deleted or inserted, so a sustained rate mismatch leads to overflow or underflow.
- R7: A write into a full buffer sets a sticky overflow flag and discards that column. Writes stay refused until the write-side fill is at most half (8).
- R8: A read of an empty buffer sets a sticky underflow flag and produces an idle column. Reading pauses until the read-side fill reaches half (8).
- R9: Each pointer copy that crosses between the clocks changes by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| wr_clk | input | 1 | Recovered clock for incoming columns |
| wr_valid | input | 1 | Incoming column present this cycle |
| wr_data | input | 32 | Incoming column bytes, lane i in bits 8i+7:8i |
| wr_ctl | input | 4 | Incoming per-lane control flags |
| lane_sync | input | 1 | Receiver in sync (write domain); enables deletion and insertion |
| rd_clk | input | 1 | Local clock for outgoing columns |
| rd_data | output | 32 | Outgoing column bytes |
| rd_ctl | output | 4 | Outgoing per-lane control flags |
| ovf_err | output | 1 | Sticky overflow flag (write domain) |
| unf_err | output | 1 | Sticky underflow flag (read domain) |

## Verification
The main function is driven with streams that mix plain data columns with two kinds of near-idle column: three idle lanes plus one data lane, and four idle bytes with one control flag cleared. Idle columns are placed every fourth or every eighth column. With the write clock 10% fast, the count of idle columns at the output must fall below the count written, which shows that deletion took place. With the read clock 10% fast, the count must rise above it, which shows that insertion took place. In both cases every data column must appear in order, which shows that no data was lost or repeated. The same mismatched clock pairs are then run with lane sync low, where only an overflow or an underflow can result. This separates a gated adjustment from one that is merely delayed, and a follow-on stream checks that the sticky flags hold while the data path recovers.

// File: rtl/ceb_pkg.sv
package ceb_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  typedef struct packed {
    logic [LANES-1:0]  ctl;
    logic [DATA_W-1:0] dat;
  } col_t;

  // A column counts as idle only when every lane holds the idle code as a control byte.
  function automatic logic col_is_idle(col_t c, logic [BYTE_W-1:0] code);
    logic ok;
    ok = &c.ctl;
    for (int i = 0; i < LANES; i++) begin
      if (c.dat[i*BYTE_W +: BYTE_W] != code) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic col_t idle_col(logic [BYTE_W-1:0] code);
    col_t c;
    c.ctl = '1;
    for (int i = 0; i < LANES; i++) c.dat[i*BYTE_W +: BYTE_W] = code;
    return c;
  endfunction
endpackage

// File: rtl/ceb_rst_sync.sv
module ceb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/ceb_ptr_sync.sv
module ceb_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_in;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/ceb_wr_ctl.sv
module ceb_wr_ctl
  import ceb_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter int          DEL_TH    = 10,
  parameter logic [7:0]  IDLE_BYTE = 8'h07,
  localparam int         AW        = $clog2(DEPTH),
  localparam int         PW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  col_t          in_col,
  input  logic          lane_sync,
  input  logic [PW-1:0] rptr_bin,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [PW-1:0] wptr_gray,
  output logic          ovf_err
);
  localparam int HALF = DEPTH / 2;

  typedef enum logic {W_RUN, W_DRAIN} wst_e;

  wst_e          st_q, st_d;
  logic          err_q, err_d;
  logic [PW-1:0] wptr_q, wptr_d, gray_q;
  logic [PW-1:0] wfill;
  logic          drop_idle;

  assign wfill = wptr_q - rptr_bin;

  always_comb begin
    st_d      = st_q;
    err_d     = err_q;
    mem_we    = 1'b0;
    drop_idle = in_valid && lane_sync && col_is_idle(in_col, IDLE_BYTE) &&
                (wfill > PW'(DEL_TH));
    case (st_q)
      W_RUN: begin
        if (in_valid && !drop_idle) begin
          if (wfill == PW'(DEPTH)) begin
            err_d = 1'b1;
            st_d  = W_DRAIN;
          end else begin
            mem_we = 1'b1;
          end
        end
      end
      default: begin
        if (wfill <= PW'(HALF)) st_d = W_RUN;
      end
    endcase
    wptr_d = wptr_q + PW'(mem_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_RUN;
      err_q  <= 1'b0;
      wptr_q <= '0;
      gray_q <= '0;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      wptr_q <= wptr_d;
      gray_q <= wptr_d ^ (wptr_d >> 1);
    end
  end

  assign mem_addr  = wptr_q[AW-1:0];
  assign wptr_gray = gray_q;
  assign ovf_err   = err_q;

  assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wfill != PW'(DEPTH)));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  assert_no_delete_unsynced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lane_sync && st_q == W_RUN && wfill != PW'(DEPTH)) |-> mem_we);
  assert_wr_gray_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);
endmodule

// File: rtl/ceb_rd_ctl.sv
module ceb_rd_ctl
  import ceb_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter int          INS_TH    = 6,
  parameter logic [7:0]  IDLE_BYTE = 8'h07,
  localparam int         AW        = $clog2(DEPTH),
  localparam int         PW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  col_t          head,
  input  logic [PW-1:0] wptr_bin,
  input  logic          lane_sync,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rptr_gray,
  output col_t          out_col,
  output logic          unf_err
);
  localparam int HALF = DEPTH / 2;

  typedef enum logic {R_FILL, R_RUN} rst_e;

  rst_e          st_q, st_d;
  logic          err_q, err_d;
  logic [PW-1:0] rptr_q, rptr_d, gray_q;
  logic [PW-1:0] rfill;
  col_t          out_q, out_d;
  logic          adv;

  assign rfill = wptr_bin - rptr_q;

  always_comb begin
    st_d  = st_q;
    err_d = err_q;
    out_d = idle_col(IDLE_BYTE);
    adv   = 1'b0;
    case (st_q)
      R_FILL: begin
        if (rfill >= PW'(HALF)) st_d = R_RUN;
      end
      default: begin
        if (rfill == '0) begin
          err_d = 1'b1;
          st_d  = R_FILL;
        end else begin
          out_d = head;
          adv   = !(lane_sync && col_is_idle(head, IDLE_BYTE) && (rfill < PW'(INS_TH)));
        end
      end
    endcase
    rptr_d = rptr_q + PW'(adv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= R_FILL;
      err_q  <= 1'b0;
      rptr_q <= '0;
      gray_q <= '0;
      out_q  <= idle_col(IDLE_BYTE);
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      rptr_q <= rptr_d;
      gray_q <= rptr_d ^ (rptr_d >> 1);
      out_q  <= out_d;
    end
  end

  assign rd_addr   = rptr_q[AW-1:0];
  assign rptr_gray = gray_q;
  assign out_col   = out_q;
  assign unf_err   = err_q;

  assert_underflow_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == R_RUN && rfill == '0) |=> (unf_err && col_is_idle(out_col, IDLE_BYTE)));
  assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> unf_err);
  assert_insert_is_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == R_RUN && rfill != '0 && !adv) |=> col_is_idle(out_col, IDLE_BYTE));
  assert_no_insert_unsynced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == R_RUN && rfill != '0 && !lane_sync) |=> (rptr_q == $past(rptr_q) + 1'b1));
  assert_rd_gray_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);
endmodule

// File: rtl/column_elastic_buf.sv
module column_elastic_buf
  import ceb_pkg::*;
#(
  parameter int         DEPTH     = 16,
  parameter int         DEL_TH    = 10,
  parameter int         INS_TH    = 6,
  parameter logic [7:0] IDLE_BYTE = 8'h07
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_ctl,
  input  logic              lane_sync,
  input  logic              rd_clk,
  output logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  rd_ctl,
  output logic              ovf_err,
  output logic              unf_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wr_rst_n, rd_rst_n;
  logic          mem_we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wptr_gray, rptr_gray, wptr_in_rd, rptr_in_wr;
  logic          sync_in_rd;
  col_t          in_col, head, out_col;
  col_t          mem [DEPTH];

  ceb_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_n));
  ceb_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_n));

  assign in_col = '{ctl: wr_ctl, dat: wr_data};

  ceb_wr_ctl #(.DEPTH(DEPTH), .DEL_TH(DEL_TH), .IDLE_BYTE(IDLE_BYTE)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(wr_valid), .in_col(in_col),
    .lane_sync(lane_sync), .rptr_bin(rptr_in_wr), .mem_we(mem_we),
    .mem_addr(waddr), .wptr_gray(wptr_gray), .ovf_err(ovf_err)
  );

  always_ff @(posedge wr_clk) begin
    if (mem_we) mem[waddr] <= in_col;
  end

  assign head = mem[raddr];

  ceb_ptr_sync #(.W(PW)) u_rptr_to_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(rptr_gray), .bin_out(rptr_in_wr)
  );
  ceb_ptr_sync #(.W(PW)) u_wptr_to_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wptr_gray), .bin_out(wptr_in_rd)
  );
  ceb_ptr_sync #(.W(1)) u_sync_to_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(lane_sync), .bin_out(sync_in_rd)
  );

  ceb_rd_ctl #(.DEPTH(DEPTH), .INS_TH(INS_TH), .IDLE_BYTE(IDLE_BYTE)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .head(head), .wptr_bin(wptr_in_rd),
    .lane_sync(sync_in_rd), .rd_addr(raddr), .rptr_gray(rptr_gray),
    .out_col(out_col), .unf_err(unf_err)
  );

  assign rd_data = out_col.dat;
  assign rd_ctl  = out_col.ctl;
endmodule

// File: tb/column_elastic_buf_tb.sv
`timescale 1ns/1ps
module column_elastic_buf_tb;
  localparam real        CLK_PERIOD = 10.0;
  localparam logic [7:0] IDLE       = 8'h07;

  logic        rst_n, wr_clk, rd_clk, wr_valid, lane_sync;
  logic [31:0] wr_data, rd_data;
  logic [3:0]  wr_ctl, rd_ctl;
  logic        ovf_err, unf_err;
  real         rd_half = 5.0;

  int n_checks = 0, n_fail = 0;
  int in_r, out_r, mism;
  logic [35:0] first_act, first_exp;
  logic        mon_on = 1'b0;
  logic [35:0] sb [$];

  column_elastic_buf u_dut (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ctl(wr_ctl), .lane_sync(lane_sync), .rd_clk(rd_clk), .rd_data(rd_data),
    .rd_ctl(rd_ctl), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  initial wr_clk = 1'b0;
  always #(CLK_PERIOD/2.0) wr_clk = ~wr_clk;
  initial rd_clk = 1'b0;
  always #(rd_half) rd_clk = ~rd_clk;

  function automatic logic is_idle(logic [35:0] c);
    return c == {4'hF, {4{IDLE}}};
  endfunction

  // Stream generator: idle columns at a fixed spacing, near-idle columns mixed in (R5).
  function automatic logic [35:0] make_col(int k, int r_every);
    logic [15:0] kk;
    kk = 16'(k);
    if (k % r_every == r_every - 1) return {4'hF, {4{IDLE}}};
    if (k % 16 == 5) return {4'hF, IDLE, IDLE, IDLE, kk[7:0]};
    if (k % 16 == 9) return {4'b0111, {4{IDLE}}};
    return {4'h0, kk[7:0] ^ 8'h3C, kk[15:8], kk[7:0], 8'hA0 + {4'h0, kk[3:0]}};
  endfunction

  always @(negedge rd_clk) begin
    if (mon_on) begin
      if (is_idle({rd_ctl, rd_data})) out_r++;
      else if (sb.size() == 0) begin
        if (mism == 0) begin first_act = {rd_ctl, rd_data}; first_exp = '0; end
        mism++;
      end else begin
        logic [35:0] e;
        e = sb.pop_front();
        if (e != {rd_ctl, rd_data}) begin
          if (mism == 0) begin first_act = {rd_ctl, rd_data}; first_exp = e; end
          mism++;
        end
      end
    end
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input real rdh, input logic sync);
    mon_on = 1'b0;
    wr_valid = 1'b0;
    wr_data = '0;
    wr_ctl = '0;
    lane_sync = sync;
    rst_n = 1'b0;
    rd_half = rdh;
    sb.delete();
    in_r = 0; out_r = 0; mism = 0;
    repeat (4) @(posedge wr_clk);
    rst_n = 1'b1;
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
  endtask

  task automatic put_col(input logic [35:0] c);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    {wr_ctl, wr_data} = c;
    if (is_idle(c)) in_r++;
    else sb.push_back(c);
  endtask

  task automatic run_stream(input int n, input int r_every, input logic mon);
    mon_on = mon;
    for (int k = 0; k < n; k++) put_col(make_col(k, r_every));
    for (int k = 0; k < 40; k++) put_col({4'hF, {4{IDLE}}});
    mon_on = 1'b0;
  endtask

  task automatic end_writes();
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  task automatic test_reset();
    do_reset(5.0, 1'b1);
    @(negedge rd_clk);
    check({rd_ctl, rd_data} == {4'hF, {4{IDLE}}}, "R1 idle column after reset",
          64'({rd_ctl, rd_data}), 64'({4'hF, {4{IDLE}}}));
    check(ovf_err == 1'b0, "R1 ovf_err clear", 64'(ovf_err), 64'(0));
    check(unf_err == 1'b0, "R1 unf_err clear", 64'(unf_err), 64'(0));
  endtask

  task automatic test_delete();
    do_reset(5.5, 1'b1);
    run_stream(600, 4, 1'b1);
    check(mism == 0, "R2 data order with fast writer", 64'(first_act), 64'(first_exp));
    check(sb.size() == 0, "R2 all data delivered", 64'(sb.size()), 64'(0));
    check(out_r < in_r, "R3 idle columns deleted", 64'(out_r), 64'(in_r));
    check(!ovf_err && !unf_err, "R3 no error while compensating", 64'({ovf_err, unf_err}), 64'(0));
    end_writes();
  endtask

  task automatic test_insert();
    do_reset(4.5, 1'b1);
    run_stream(600, 4, 1'b1);
    check(mism == 0, "R2 data order with fast reader", 64'(first_act), 64'(first_exp));
    check(sb.size() == 0, "R2 all data delivered", 64'(sb.size()), 64'(0));
    check(out_r > in_r, "R4 idle columns inserted", 64'(out_r), 64'(in_r));
    check(!ovf_err && !unf_err, "R4 no error while compensating", 64'({ovf_err, unf_err}), 64'(0));
    end_writes();
  endtask

  task automatic test_near_idle();
    do_reset(5.0, 1'b1);
    run_stream(400, 8, 1'b1);
    check(mism == 0, "R5 near-idle columns kept as data", 64'(first_act), 64'(first_exp));
    check(sb.size() == 0, "R5 near-idle columns all delivered", 64'(sb.size()), 64'(0));
    check(!ovf_err && !unf_err, "R5 no error at matched rates", 64'({ovf_err, unf_err}), 64'(0));
    end_writes();
  endtask

  task automatic test_overflow();
    do_reset(5.5, 1'b0);
    run_stream(300, 4, 1'b0);
    check(ovf_err == 1'b1, "R6 no deletion when unsynced -> overflow", 64'(ovf_err), 64'(1));
    lane_sync = 1'b1;
    run_stream(150, 4, 1'b0);
    check(ovf_err == 1'b1, "R7 overflow flag sticky", 64'(ovf_err), 64'(1));
    check(unf_err == 1'b0, "R7 no underflow on slow reader", 64'(unf_err), 64'(0));
    end_writes();
  endtask

  task automatic test_underflow();
    do_reset(4.5, 1'b0);
    run_stream(300, 4, 1'b0);
    check(unf_err == 1'b1, "R6 no insertion when unsynced -> underflow", 64'(unf_err), 64'(1));
    check(ovf_err == 1'b0, "R8 no overflow on fast reader", 64'(ovf_err), 64'(0));
    lane_sync = 1'b1;
    sb.delete();
    in_r = 0; out_r = 0; mism = 0;
    run_stream(300, 4, 1'b1);
    check(mism == 0, "R8 data intact after underflow recovery", 64'(first_act), 64'(first_exp));
    check(unf_err == 1'b1, "R8 underflow flag sticky", 64'(unf_err), 64'(1));
    end_writes();
  endtask

  initial begin
    #(CLK_PERIOD * 150000.0);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_valid = 1'b0;
    wr_data = '0;
    wr_ctl = '0;
    lane_sync = 1'b0;
    test_reset();
    test_delete();
    test_insert();
    test_near_idle();
    test_overflow();
    test_underflow();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule